// File: doc/BRIEF.md
# Initial-State Identifier for a Four-State Mealy Machine

This block connects to the input and output of a fixed four-state Mealy machine whose present state is not known. When asked, it advances the machine for exactly two cycles. It feeds the input symbol 0 in the first cycle and the symbol 1 in the second. It records the Mealy output bit seen in each of those cycles.

The four possible two-bit responses are all different. The block therefore decodes the response into the state the machine was in before the probe. Because the probe also homes the machine, the block reports the state the machine has reached as well. Both codes appear together with a one-cycle valid pulse and hold their values until the next report.

The machine's transitions, with the code written beside each state name, are:

| State | Input 0: next state, output | Input 1: next state, output |
|---|---|---|
| A (00) | B, 1 | C, 0 |
| B (01) | A, 0 | D, 1 |
| C (10) | B, 0 | A, 0 |
| D (11) | C, 1 | A, 1 |

The block never reads the machine's state register. It relies only on the output bits. It also drives a step enable, so that the machine advances only during the two probe cycles.

Top module: `dsid_top`

## Requirements
- R1: While reset is low, and in the first cycle after it, `mach_step`, `mach_drive` and `id_valid` are 0, and `init_code` and `now_code` are 00.
- R2: A high `id_req` sampled at a rising edge while the block is idle makes `mach_step`=1 with `mach_drive`=0 in the next cycle, then `mach_step`=1 with `mach_drive`=1 in the cycle after that.
- R3: The response is taken as the ordered pair (output in the drive-0 cycle, output in the drive-1 cycle). The pair 11 reports `init_code`=00 (A), 00 reports 01 (B), 01 reports 10 (C) and 10 reports 11 (D).
- R4: `now_code` reports the state after the probe. Start A gives 11 (D), start B gives 10 (C), start C gives 11 (D) and start D gives 00 (A).
- R5: `id_valid` is high for exactly one cycle, in the cycle right after the drive-1 cycle. `init_code` and `now_code` change only in a cycle where `id_valid` is high.
- R6: A request sampled during either probe cycle or during the valid cycle is ignored. The probe runs to its end unchanged, and no new probe starts until the block is idle again.
- R7: Outside the two probe cycles `mach_step` and `mach_drive` are 0, so the machine keeps its state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| id_req | input | 1 | Request to identify the machine's state |
| mach_resp | input | 1 | Mealy output bit of the attached machine |
| mach_drive | output | 1 | Input symbol fed to the machine |
| mach_step | output | 1 | Advance enable for the machine |
| init_code | output | 2 | Identified state before the probe |
| now_code | output | 2 | State of the machine after the probe |
| id_valid | output | 1 | One-cycle pulse marking a fresh report |

## Verification
The checker tests the following on every cycle:
- the drive-0 cycle is always followed by the drive-1 cycle, and the drive-1 cycle by the valid pulse;
- valid never lasts two cycles;
- the drive bit is never high without the step enable;
- the reported codes move only together with valid;
- the reported before and after states always differ, which holds for every row of the machine.

Only the bench scenarios can show that each of the four starting states is named correctly. It compares the block against a behavioural copy of the machine whose true starting state it knows. The same scenarios show that requests held high through a probe do not restart or extend it.

// File: rtl/dsid_pkg.sv
package dsid_pkg;

  localparam int STATE_W = 2;
  localparam int SEQ_LEN = 2;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_FIRST  = 2'd1,
    PH_SECOND = 2'd2,
    PH_REPORT = 2'd3
  } phase_t;

  // Input symbol applied at probe position idx (0 first, then 1).
  function automatic logic probe_symbol(input int idx);
    return (idx == 1);
  endfunction

  // resp = {output in first probe cycle, output in second probe cycle}
  function automatic logic [STATE_W-1:0] resp_to_initial(input logic [SEQ_LEN-1:0] resp);
    logic [STATE_W-1:0] s;
    case (resp)
      2'b11:   s = 2'd0;
      2'b00:   s = 2'd1;
      2'b01:   s = 2'd2;
      default: s = 2'd3;
    endcase
    return s;
  endfunction

  function automatic logic [STATE_W-1:0] initial_to_final(input logic [STATE_W-1:0] s0);
    logic [STATE_W-1:0] s;
    case (s0)
      2'd0:    s = 2'd3;
      2'd1:    s = 2'd2;
      2'd2:    s = 2'd3;
      default: s = 2'd0;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/dsid_sequencer.sv
module dsid_sequencer
  import dsid_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic step,
  output logic drive,
  output logic probe_idx,
  output logic last_step,
  output logic report
);

  phase_t phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    case (phase_q)
      PH_IDLE:   if (req) phase_d = PH_FIRST;
      PH_FIRST:  phase_d = PH_SECOND;
      PH_SECOND: phase_d = PH_REPORT;
      default:   phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

  assign step      = (phase_q == PH_FIRST) || (phase_q == PH_SECOND);
  assign probe_idx = (phase_q == PH_SECOND);
  assign drive     = step && probe_symbol(int'(probe_idx));
  assign last_step = (phase_q == PH_SECOND);
  assign report    = (phase_q == PH_REPORT);

endmodule

// File: rtl/dsid_capture.sv
module dsid_capture
  import dsid_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               step,
  input  logic               probe_idx,
  input  logic               resp,
  output logic [SEQ_LEN-1:0] bits
);

  for (genvar i = 0; i < SEQ_LEN; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)                                   bits[i] <= 1'b0;
      else if (step && (int'(probe_idx) == i))      bits[i] <= resp;
    end
  end

endmodule

// File: rtl/dsid_decoder.sv
module dsid_decoder
  import dsid_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               last_step,
  input  logic [SEQ_LEN-1:0] bits,
  input  logic               live_resp,
  output logic [STATE_W-1:0] init_code,
  output logic [STATE_W-1:0] now_code
);

  logic [SEQ_LEN-1:0] word;
  logic [STATE_W-1:0] init_d;

  // first response in the MSB; second taken live in the last probe cycle
  assign word   = {bits[0], live_resp};
  assign init_d = resp_to_initial(word);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      init_code <= '0;
      now_code  <= '0;
    end else if (last_step) begin
      init_code <= init_d;
      now_code  <= initial_to_final(init_d);
    end
  end

endmodule

// File: rtl/dsid_top.sv
module dsid_top
  import dsid_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               id_req,
  input  logic               mach_resp,
  output logic               mach_drive,
  output logic               mach_step,
  output logic [STATE_W-1:0] init_code,
  output logic [STATE_W-1:0] now_code,
  output logic               id_valid
);

  logic               probe_idx;
  logic               last_step;
  logic [SEQ_LEN-1:0] cap_bits;

  dsid_sequencer u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (id_req),
    .step      (mach_step),
    .drive     (mach_drive),
    .probe_idx (probe_idx),
    .last_step (last_step),
    .report    (id_valid)
  );

  dsid_capture u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (mach_step),
    .probe_idx (probe_idx),
    .resp      (mach_resp),
    .bits      (cap_bits)
  );

  dsid_decoder u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .last_step (last_step),
    .bits      (cap_bits),
    .live_resp (mach_resp),
    .init_code (init_code),
    .now_code  (now_code)
  );

endmodule

// File: rtl/dsid_checker.sv
module dsid_checker
  import dsid_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               mach_drive,
  input logic               mach_step,
  input logic [STATE_W-1:0] init_code,
  input logic [STATE_W-1:0] now_code,
  input logic               id_valid
);

  a_r2_first_then_second: assert property (@(posedge clk) disable iff (!rst_n)
    (mach_step && !mach_drive) |=> (mach_step && mach_drive));

  a_r5_valid_after_second: assert property (@(posedge clk) disable iff (!rst_n)
    (mach_step && mach_drive) |=> id_valid);

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    id_valid |=> !id_valid);

  a_r6_no_extension: assert property (@(posedge clk) disable iff (!rst_n)
    (mach_step && mach_drive) |=> !mach_step);

  a_r7_drive_needs_step: assert property (@(posedge clk) disable iff (!rst_n)
    mach_drive |-> mach_step);

  a_r5_codes_move_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(init_code) || !$stable(now_code)) |-> id_valid);

  a_r4_state_moved: assert property (@(posedge clk) disable iff (!rst_n)
    id_valid |-> (now_code != init_code));

endmodule

bind dsid_top dsid_checker u_chk (.*);

// File: tb/sim_dsid_top.sv
module sim_dsid_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       id_req = 1'b0;
  logic       mach_resp;
  logic       mach_drive;
  logic       mach_step;
  logic [1:0] init_code;
  logic [1:0] now_code;
  logic       id_valid;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  dsid_top u0 (
    .clk(clk), .rst_n(rst_n), .id_req(id_req), .mach_resp(mach_resp),
    .mach_drive(mach_drive), .mach_step(mach_step),
    .init_code(init_code), .now_code(now_code), .id_valid(id_valid)
  );

  // behavioural machine: returns {next state, output}
  function automatic logic [2:0] mealy(input logic [1:0] s, input logic x);
    case ({s, x})
      3'b000: return {2'd1, 1'b1};
      3'b001: return {2'd2, 1'b0};
      3'b010: return {2'd0, 1'b0};
      3'b011: return {2'd3, 1'b1};
      3'b100: return {2'd1, 1'b0};
      3'b101: return {2'd0, 1'b0};
      3'b110: return {2'd2, 1'b1};
      default: return {2'd0, 1'b1};
    endcase
  endfunction

  logic [1:0] mstate = 2'd0;
  logic       seed_req = 1'b0;
  logic [1:0] seed_val = 2'd0;
  logic [2:0] lut_now;

  assign lut_now   = mealy(mstate, mach_drive);
  assign mach_resp = lut_now[0];

  // reference model
  int         rphase = 0;
  logic [1:0] start_seen = 2'd0;
  logic [1:0] exp_init = 2'd0;
  logic [1:0] exp_now = 2'd0;

  always @(posedge clk) begin
    logic [2:0] r;
    if (!rst_n) begin
      rphase = 0; exp_init = 2'd0; exp_now = 2'd0;
      if (seed_req) mstate <= seed_val;
    end else begin
      r = mealy(mstate, rphase == 2);
      case (rphase)
        0: begin
          if (seed_req) mstate <= seed_val;
          if (id_req) rphase = 1;
        end
        1: begin start_seen = mstate; mstate <= r[2:1]; rphase = 2; end
        2: begin exp_init = start_seen; exp_now = r[2:1]; mstate <= r[2:1]; rphase = 3; end
        default: rphase = 0;
      endcase
    end
  end

  task automatic cmp(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      cmp("R2,R6,R7 mach_step", int'(mach_step), int'(rphase == 1 || rphase == 2));
      cmp("R2,R7 mach_drive", int'(mach_drive), int'(rphase == 2));
      cmp("R5,R6 id_valid", int'(id_valid), int'(rphase == 3));
      cmp("R3 init_code", int'(init_code), int'(exp_init));
      cmp("R4 now_code", int'(now_code), int'(exp_now));
    end
  end

  task automatic seed(input logic [1:0] s);
    @(negedge clk); seed_val = s; seed_req = 1'b1;
    @(negedge clk); seed_req = 1'b0;
  endtask

  task automatic probe_once(input logic [1:0] s);
    seed(s);
    @(negedge clk); id_req = 1'b1;
    @(negedge clk); id_req = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    cmp("R1 reset step", int'(mach_step), 0);
    cmp("R1 reset valid", int'(id_valid), 0);
    cmp("R1 reset init", int'(init_code), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R3 R4: every start state
    for (int s = 0; s < 4; s++) probe_once(2'(s));
    probe_once(2'd3);
    probe_once(2'd1);
    // R6: request held high through many probes, back to back
    seed(2'd2);
    @(negedge clk); id_req = 1'b1;
    repeat (20) @(negedge clk);
    id_req = 1'b0;
    repeat (6) @(negedge clk);
    // R6: request pulsed in each busy cycle individually
    seed(2'd0);
    @(negedge clk); id_req = 1'b1;
    @(negedge clk); id_req = 1'b0;
    id_req = 1'b1; @(negedge clk);
    id_req = 1'b1; @(negedge clk);
    id_req = 1'b0;
    repeat (6) @(negedge clk);
    // R7: idle, no request, machine must hold
    repeat (10) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule